// File: doc/BRIEF.md
# Seven-Level Staircase Level Sequencer

This block produces, for three phases 120 degrees apart, the level command for a seven-level staircase waveform that switches once per fundamental period. A 16-bit phase word advances by a programmable step on every clock. Three programmable step angles divide each quarter cycle into four bands. The result is a signed level from -3 to +3, in units of half the source voltage. The waveform has odd quarter-wave symmetry: it rises through the angles in the first quarter, falls back at their mirror points in the second quarter, and repeats negated in the second half.

A square wave at three times the fundamental, with an amplitude of one level, can be added to all three phases. The added wave is the same on every phase, so it cancels between phases. The sum is saturated to the seven-level range. The step size, angles and injection enable are held in shadow copies that take effect only when the phase word wraps. A registered flag reports a requested modulation index beyond the range in which the flying capacitor can be kept balanced.

Top module: `staircase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the phase word and all three levels become 0, the range flag becomes 0, and the step size, angles and injection enable are copied from the inputs into the active settings.
- R2: In the first quarter (phase bits [15:14] = 00), the magnitude equals the number of angles a_k with a_k <= f, where f = phase bits [13:0].
- R3: In the second quarter (bits [15:14] = 01), the magnitude equals the number of angles a_k with a_k <= 16383 - f. The level therefore falls back at the mirror points of the angles.
- R4: When phase bit 15 is 1, the level is the negation of the magnitude computed as in R2/R3 from bits [14:0]. Without injection, the level is >= 0 when bit 15 is 0 and <= 0 when bit 15 is 1.
- R5: The phase word advances by the active step, modulo 2^16, on each clock. The level outputs are registered and reflect the phase word of the previous cycle.
- R6: With injection active, +1 is added when bit 15 of (3 x phase_A mod 2^16) is 0, and -1 is added otherwise. The same term is applied to all three phases.
- R7: The summed level is saturated to the range -3..+3. The encoding -4 never appears.
- R8: Phase B uses (phase - 21845) mod 2^16 and phase C uses (phase - 43691) mod 2^16.
- R9: New step, angle and injection-enable inputs become active only at the clock on which the phase addition carries out of bit 15.
- R10: `range_flag` is registered from the live inputs. `mi_code` is unsigned with 8 fraction bits. The flag is 1 when `mi_code` > 394 with `inj_en` = 0, or when `mi_code` > 507 with `inj_en` = 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 16 | Phase increment per clock (shadowed) |
| ang1_in | input | 14 | First step angle, quarter-cycle fraction (shadowed) |
| ang2_in | input | 14 | Second step angle (shadowed) |
| ang3_in | input | 14 | Third step angle (shadowed) |
| inj_en | input | 1 | Enable third-harmonic square injection (shadowed) |
| mi_code | input | 10 | Requested modulation index, 8 fraction bits |
| lvl_a | output | 3 | Signed level, phase A |
| lvl_b | output | 3 | Signed level, phase B |
| lvl_c | output | 3 | Signed level, phase C |
| range_flag | output | 1 | Modulation index beyond balance limit |

## Verification
The staircase is exercised with several patterns, and each one separates a different part of the logic:
- widely spaced angles at a coarse step, which show the rise through the angles, the mirrored fall and the sign flip;
- angles at 0 and at 16383, which probe the comparison edges at both ends of a quarter;
- closely packed angles at odd step sizes, which land the phase on many distinct fractions;
- a step of 65535, which runs the phase backwards.

Injection runs with both zero angles and normal angles, which separates the +1/-1 term from saturation. A mid-cycle change of the angles and the injection enable confirms that the old settings hold until the wrap. The flag is probed on both sides of each limit.

// File: rtl/sts_pkg.sv
`timescale 1ns/1ps
package sts_pkg;
    localparam int PHASE_W   = 16;
    localparam int ANG_W     = PHASE_W - 2;
    localparam int MI_W      = 10;
    localparam int LVL_W     = 3;
    localparam int LIM_PLAIN = 394;   // about 1.54 in Q2.8
    localparam int LIM_INJ   = 507;   // about 1.98 in Q2.8
    localparam int NPH       = 3;

    typedef logic signed [LVL_W-1:0] level_t;

    typedef struct packed {
        logic [ANG_W-1:0] a1;
        logic [ANG_W-1:0] a2;
        logic [ANG_W-1:0] a3;
        logic             inj;
    } angle_set_t;

    function automatic logic [PHASE_W-1:0] phase_offset(input int idx);
        return PHASE_W'((idx * (1 << PHASE_W) + 1) / 3);
    endfunction
endpackage

// File: rtl/sts_phase_acc.sv
`timescale 1ns/1ps
module sts_phase_acc
    import sts_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step_in,
    input  angle_set_t         set_in,
    output logic [PHASE_W-1:0] phase,
    output angle_set_t         set_act,
    output logic               inj_neg
);
    logic [PHASE_W-1:0] step_act;
    logic [PHASE_W:0]   sum;
    logic               wrap;
    logic [PHASE_W+1:0] triple;

    always_comb begin
        sum  = {1'b0, phase} + {1'b0, step_act};
        wrap = sum[PHASE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            step_act <= step_in;
            set_act  <= set_in;
        end else begin
            phase <= sum[PHASE_W-1:0];
            if (wrap) begin
                step_act <= step_in;
                set_act  <= set_in;
            end
        end
    end

    always_comb begin
        triple  = {2'b00, phase} + {1'b0, phase, 1'b0};
        inj_neg = triple[PHASE_W-1];
    end

    AST_SET_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(set_act)); // R9
    AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(step_act)); // R9
endmodule

// File: rtl/sts_level_map.sv
`timescale 1ns/1ps
module sts_level_map
    import sts_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] ph,
    input  angle_set_t         set_act,
    input  logic               inj_neg,
    output level_t             lvl
);
    logic [1:0]       quad;
    logic [ANG_W-1:0] frac;
    logic [ANG_W-1:0] folded;
    logic [1:0]       cnt;
    logic signed [3:0] base;
    logic signed [3:0] adj;
    logic signed [3:0] total;
    level_t           clamped;

    always_comb begin
        quad   = ph[PHASE_W-1:PHASE_W-2];
        frac   = ph[ANG_W-1:0];
        folded = quad[0] ? ~frac : frac;
        cnt    = 2'(folded >= set_act.a1) + 2'(folded >= set_act.a2)
               + 2'(folded >= set_act.a3);
        base   = quad[1] ? -$signed({2'b00, cnt}) : $signed({2'b00, cnt});
        if (!set_act.inj)  adj = 4'sd0;
        else if (inj_neg)  adj = -4'sd1;
        else               adj = 4'sd1;
        total  = base + adj;
        if (total > 4'sd3)       clamped = 3'sd3;
        else if (total < -4'sd3) clamped = -3'sd3;
        else                     clamped = total[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) lvl <= '0;
        else     lvl <= clamped;
    end

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        lvl != -3'sd4); // R7
    AST_POS_HALF: assert property (@(posedge clk) disable iff (rst)
        (!set_act.inj && !ph[PHASE_W-1]) |=> (lvl >= 3'sd0)); // R4
    AST_NEG_HALF: assert property (@(posedge clk) disable iff (rst)
        (!set_act.inj && ph[PHASE_W-1]) |=> (lvl <= 3'sd0)); // R4
endmodule

// File: rtl/sts_range_chk.sv
`timescale 1ns/1ps
module sts_range_chk
    import sts_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [MI_W-1:0] mi_code,
    input  logic            inj_en,
    output logic            range_flag
);
    logic over;

    always_comb begin
        if (inj_en) over = (int'(mi_code) > LIM_INJ);
        else        over = (int'(mi_code) > LIM_PLAIN);
    end

    always_ff @(posedge clk) begin
        if (rst) range_flag <= 1'b0;
        else     range_flag <= over;
    end

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!inj_en && int'(mi_code) <= LIM_PLAIN) |=> !range_flag); // R10
    AST_FLAG_HIGH: assert property (@(posedge clk) disable iff (rst)
        (int'(mi_code) > LIM_INJ) |=> range_flag); // R10
endmodule

// File: rtl/staircase_seq.sv
`timescale 1ns/1ps
module staircase_seq
    import sts_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step_in,
    input  logic [ANG_W-1:0]   ang1_in,
    input  logic [ANG_W-1:0]   ang2_in,
    input  logic [ANG_W-1:0]   ang3_in,
    input  logic               inj_en,
    input  logic [MI_W-1:0]    mi_code,
    output logic signed [LVL_W-1:0] lvl_a,
    output logic signed [LVL_W-1:0] lvl_b,
    output logic signed [LVL_W-1:0] lvl_c,
    output logic               range_flag
);
    angle_set_t         set_in;
    angle_set_t         set_act;
    logic [PHASE_W-1:0] phase;
    logic               inj_neg;
    level_t             lvl [NPH];

    always_comb begin
        set_in.a1  = ang1_in;
        set_in.a2  = ang2_in;
        set_in.a3  = ang3_in;
        set_in.inj = inj_en;
    end

    sts_phase_acc acc_i (
        .clk(clk), .rst(rst), .step_in(step_in), .set_in(set_in),
        .phase(phase), .set_act(set_act), .inj_neg(inj_neg)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        logic [PHASE_W-1:0] ph_g;
        always_comb ph_g = phase - phase_offset(g);
        sts_level_map map_i (
            .clk(clk), .rst(rst), .ph(ph_g), .set_act(set_act),
            .inj_neg(inj_neg), .lvl(lvl[g])
        );
    end

    assign lvl_a = lvl[0];
    assign lvl_b = lvl[1];
    assign lvl_c = lvl[2];

    sts_range_chk chk_i (
        .clk(clk), .rst(rst), .mi_code(mi_code), .inj_en(inj_en),
        .range_flag(range_flag)
    );
endmodule

// File: tb/staircase_seq_tb_top.sv
`timescale 1ns/1ps
module staircase_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] step_in = '0;
    logic [13:0] ang1_in = '0, ang2_in = '0, ang3_in = '0;
    logic inj_en = 1'b0;
    logic [9:0] mi_code = '0;
    logic signed [2:0] lvl_a, lvl_b, lvl_c;
    logic range_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    staircase_seq dut_i (
        .clk(clk), .rst(rst), .step_in(step_in), .ang1_in(ang1_in),
        .ang2_in(ang2_in), .ang3_in(ang3_in), .inj_en(inj_en),
        .mi_code(mi_code), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
        .range_flag(range_flag)
    );

    typedef struct packed {
        logic [15:0] step;
        logic [13:0] a1;
        logic [13:0] a2;
        logic [13:0] a3;
        logic        inj;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'd1024,  14'd2000, 14'd6000,  14'd12000, 1'b0},
        '{16'd777,   14'd3000, 14'd9000,  14'd15000, 1'b1},
        '{16'd1500,  14'd0,    14'd0,     14'd0,     1'b1},
        '{16'd4096,  14'd0,    14'd10000, 14'd16383, 1'b0},
        '{16'd333,   14'd1000, 14'd1001,  14'd1002,  1'b1},
        '{16'd65535, 14'd4000, 14'd8000,  14'd12000, 1'b0}
    };

    function automatic int exp_lvl(int p, int pa, int a1, int a2, int a3, bit inj);
        int f = p & 16383;
        int q = (p >> 14) & 3;
        int x = ((q & 1) != 0) ? (16383 - f) : f;
        int n = int'(x >= a1) + int'(x >= a2) + int'(x >= a3);
        if (q >= 2) n = -n;
        if (inj) n += ((((3 * pa) & 65535) >= 32768) ? -1 : 1);
        if (n > 3) n = 3;
        if (n < -3) n = -3;
        return n;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R1 reset lvl_a", int'(lvl_a), 0);
        check("R1 reset lvl_b", int'(lvl_b), 0);
        check("R1 reset lvl_c", int'(lvl_c), 0);
        check("R1 reset flag", int'(range_flag), 0);
        rst = 1'b0;
    endtask

    task automatic check_levels(string tag, int pa, int a1, int a2, int a3, bit inj);
        int pb = (pa - 21845) & 65535;
        int pc = (pa - 43691) & 65535;
        check({tag, " A"}, int'(lvl_a), exp_lvl(pa, pa, a1, a2, a3, inj));
        check({tag, " B R8"}, int'(lvl_b), exp_lvl(pb, pa, a1, a2, a3, inj));
        check({tag, " C R8"}, int'(lvl_c), exp_lvl(pc, pa, a1, a2, a3, inj));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // Vector table: staircase R2 R3 R4 R5, injection R6, clamp R7
        for (int v = 0; v < NVEC; v++) begin
            step_in = VECS[v].step;
            ang1_in = VECS[v].a1;
            ang2_in = VECS[v].a2;
            ang3_in = VECS[v].a3;
            inj_en  = VECS[v].inj;
            do_reset();
            for (int n = 1; n <= 300; n++) begin
                @(posedge clk); @(negedge clk);
                check_levels("R2 R3 R4 R5 R6 R7 table", ((n - 1) * int'(VECS[v].step)) & 65535,
                             int'(VECS[v].a1), int'(VECS[v].a2), int'(VECS[v].a3), VECS[v].inj);
            end
        end

        // R9: mid-cycle change holds until the wrap after 64 steps of 1024
        step_in = 16'd1024; ang1_in = 14'd4000; ang2_in = 14'd8000; ang3_in = 14'd12000;
        inj_en = 1'b0;
        do_reset();
        for (int n = 1; n <= 140; n++) begin
            @(posedge clk); @(negedge clk);
            if (n - 1 >= 64)
                check_levels("R9 new set", ((n - 1) * 1024) & 65535, 16000, 8000, 12000, 1'b1);
            else
                check_levels("R9 old set", ((n - 1) * 1024) & 65535, 4000, 8000, 12000, 1'b0);
            if (n == 5) begin
                ang1_in = 14'd16000;
                inj_en  = 1'b1;
            end
        end

        // R10: range flag on both sides of each limit
        inj_en = 1'b0; mi_code = 10'd394;
        @(posedge clk); @(negedge clk);
        check("R10 plain at limit", int'(range_flag), 0);
        mi_code = 10'd395;
        @(posedge clk); @(negedge clk);
        check("R10 plain above", int'(range_flag), 1);
        inj_en = 1'b1; mi_code = 10'd507;
        @(posedge clk); @(negedge clk);
        check("R10 inj at limit", int'(range_flag), 0);
        mi_code = 10'd508;
        @(posedge clk); @(negedge clk);
        check("R10 inj above", int'(range_flag), 1);

        // R1: reset from a running state clears outputs
        do_reset();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule